// File: doc/BRIEF.md
# Two-Set Receive DMA Ring Address Engine

This block steers received frames into a ring of fixed-size memory slots. Two register sets share one receive channel. Each set has a base address, a count of slots still free and a command register. Each time the MAC signals a frame, the active set hands out the next slot address, decrements its count and advances its slot index. When the last slot of a set is taken, the set's done flag rises, the interrupt goes high and the channel moves to the other set. Software can then stop the exhausted set, reload it and re-arm it while frames land in the other set.

A channel control register brackets a full reset of the channel and enables or disables it. Frames that cannot be placed are dropped. A frame that finds no free slot sets a sticky overflow flag. A frame that arrives while the active set is half-loaded sets an error flag, which needs a channel reset to clear. The block moves no payload. It only issues a one-cycle write strobe and the slot address for the bus master that copies the frame.

Top module: `rx_pingpong_dma`

## Requirements
- R1: After reset `wr_en_o` and `irq_o` are low. Every base, count and status register reads 0, and both command registers read 0x1100 (stopped).
- R2: Set s occupies byte offsets s*0x10 + {0x0 base, 0x4 remaining count, 0x8 command}, and the channel control/status register is at 0x20. A write to one set never changes the other set.
- R3: A frame is accepted when the channel is enabled and the active set is armed with a nonzero count. One cycle later `wr_en_o` is high for one cycle, with `wr_addr_o` = base + slot_index*0x800. That set's count then drops by 1 and its index rises by 1.
- R4: Command 0x0100 puts a set into the loading state and sets its slot index to 0. 0x9800 arms the set, and 0x1100 stops it and clears its done flag. Each command reads back as the value written, and any other value is ignored.
- R5: A count write loads min(value, 8).
- R6: When an accepted frame takes the last counted slot, the set's done flag sets and the active set toggles. Status bit 0/1 holds done for set 0/1, bit 8 holds any-done and bit 5 holds the active set.
- R7: A frame that finds the active set stopped, or armed with count 0, is dropped (no strobe) and sets sticky overflow, status bit 4.
- R8: A frame that finds the active set loading is dropped and sets error, status bit 13.
- R9: `irq_o` is high exactly when error or either done flag is set.
- R10: Control 0x8800 enters reset (status bit 3). It clears enable, error, overflow, both done flags and the active set, and stops both sets. 0x0400 leaves reset and enables the channel (bit 2), and 0x1000 disables it. Other values are ignored. Frames while disabled are dropped with no flag change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous active-low reset |
| bus_we_i | input | 1 | register write strobe |
| bus_addr_i | input | 8 | register byte offset |
| bus_wdata_i | input | 32 | register write data |
| bus_rdata_o | output | 32 | register read data (combinational on address) |
| frame_i | input | 1 | one-cycle frame arrival strobe |
| wr_en_o | output | 1 | slot write strobe |
| wr_addr_o | output | 32 | slot start address |
| irq_o | output | 1 | level interrupt |

## Verification
The bench drives a full ring through set 0 and onto set 1. A design that did not toggle the active set would keep writing past the ring end, or would flag overflow too early. A partial reload (count 3) followed by exhausting both sets checks that the slot index restarts at 0: if it did not, the addresses would carry on from the old index. The bench also covers a frame against a set in the loading state, which must raise error rather than overflow, and clamping of an oversized count. Stop, unknown commands and the disable and reset commands are each followed by status reads, which catch any flag that is wrongly kept or wrongly cleared.

// File: rtl/rxpp_pkg.sv
package rxpp_pkg;
  typedef enum logic [1:0] {SET_STOP = 2'd0, SET_LOAD = 2'd1, SET_ARM = 2'd2} set_state_e;

  localparam logic [15:0] CMD_LOAD = 16'h0100;
  localparam logic [15:0] CMD_ARM  = 16'h9800;
  localparam logic [15:0] CMD_STOP = 16'h1100;

  localparam logic [15:0] CTL_RST_ENTER = 16'h8800;
  localparam logic [15:0] CTL_RST_EXIT  = 16'h0400;
  localparam logic [15:0] CTL_DISABLE   = 16'h1000;

  localparam int OFF_BASE   = 0;
  localparam int OFF_LEN    = 4;
  localparam int OFF_CMD    = 8;
  localparam int SET_STRIDE = 16;
  localparam int OFF_CTRL   = 32;
endpackage

// File: rtl/rxpp_set.sv
module rxpp_set
  import rxpp_pkg::*;
#(
  parameter int DW    = 32,
  parameter int SLOTS = 8,
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             base_we_i,
  input  logic             len_we_i,
  input  logic             cmd_we_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             take_i,
  output logic [DW-1:0]    base_o,
  output logic [CNT_W-1:0] rem_o,
  output logic [CNT_W-1:0] idx_o,
  output set_state_e       state_o,
  output logic             done_o
);
  logic [DW-1:0]    base_q;
  logic [CNT_W-1:0] rem_q, idx_q, len_val;
  set_state_e       st_q;
  logic             done_q;
  logic [15:0]      cmd;

  assign cmd     = wdata_i[15:0];
  assign len_val = (wdata_i > DW'(SLOTS)) ? CNT_W'(SLOTS) : wdata_i[CNT_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      rem_q  <= '0;
      idx_q  <= '0;
      st_q   <= SET_STOP;
      done_q <= 1'b0;
    end else begin
      if (base_we_i) base_q <= wdata_i;

      if (len_we_i)    rem_q <= len_val;
      else if (take_i) rem_q <= rem_q - 1'b1;

      if (cmd_we_i && cmd == CMD_LOAD) idx_q <= '0;
      else if (take_i)                 idx_q <= idx_q + 1'b1;

      if (clr_i) st_q <= SET_STOP;
      else if (cmd_we_i) begin
        unique case (cmd)
          CMD_LOAD: st_q <= SET_LOAD;
          CMD_ARM:  st_q <= SET_ARM;
          CMD_STOP: st_q <= SET_STOP;
          default:  st_q <= st_q;
        endcase
      end

      // stop wins over a simultaneous last-slot take
      if (clr_i || (cmd_we_i && cmd == CMD_STOP)) done_q <= 1'b0;
      else if (take_i && rem_q == CNT_W'(1))      done_q <= 1'b1;
    end
  end

  assign base_o  = base_q;
  assign rem_o   = rem_q;
  assign idx_o   = idx_q;
  assign state_o = st_q;
  assign done_o  = done_q;
endmodule

// File: rtl/rxpp_ctrl.sv
module rxpp_ctrl
  import rxpp_pkg::*;
#(
  parameter int DW      = 32,
  parameter int CNT_W   = 4,
  parameter int SLOT_SH = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_i,
  input  logic             ctl_we_i,
  input  logic [15:0]      ctl_cmd_i,
  input  set_state_e       act_state_i,
  input  logic [CNT_W-1:0] act_rem_i,
  input  logic [DW-1:0]    act_base_i,
  input  logic [CNT_W-1:0] act_idx_i,
  output logic             take_o,
  output logic             clr_o,
  output logic             act_o,
  output logic             en_o,
  output logic             inrst_o,
  output logic             err_o,
  output logic             ovf_o,
  output logic             wr_en_o,
  output logic [DW-1:0]    wr_addr_o
);
  logic en_q, inrst_q, err_q, ovf_q, act_q, wr_en_q;
  logic [DW-1:0] wr_addr_q;
  logic miss;

  assign take_o = frame_i && en_q && act_state_i == SET_ARM && act_rem_i != '0;
  assign miss   = frame_i && en_q && !take_o;
  assign clr_o  = ctl_we_i && ctl_cmd_i == CTL_RST_ENTER;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_en_q   <= 1'b0;
      wr_addr_q <= '0;
    end else begin
      wr_en_q <= take_o;
      if (take_o) wr_addr_q <= act_base_i + (DW'(act_idx_i) << SLOT_SH);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      inrst_q <= 1'b0;
      err_q   <= 1'b0;
      ovf_q   <= 1'b0;
      act_q   <= 1'b0;
    end else if (clr_o) begin
      en_q    <= 1'b0;
      inrst_q <= 1'b1;
      err_q   <= 1'b0;
      ovf_q   <= 1'b0;
      act_q   <= 1'b0;
    end else begin
      if (ctl_we_i && ctl_cmd_i == CTL_RST_EXIT) begin
        inrst_q <= 1'b0;
        en_q    <= 1'b1;
      end else if (ctl_we_i && ctl_cmd_i == CTL_DISABLE) begin
        en_q <= 1'b0;
      end
      if (miss) begin
        if (act_state_i == SET_LOAD) err_q <= 1'b1;
        else                         ovf_q <= 1'b1;
      end
      if (take_o && act_rem_i == CNT_W'(1)) act_q <= ~act_q;
    end
  end

  assign act_o     = act_q;
  assign en_o      = en_q;
  assign inrst_o   = inrst_q;
  assign err_o     = err_q;
  assign ovf_o     = ovf_q;
  assign wr_en_o   = wr_en_q;
  assign wr_addr_o = wr_addr_q;
endmodule

// File: rtl/rx_pingpong_dma.sv
module rx_pingpong_dma
  import rxpp_pkg::*;
#(
  parameter int DW         = 32,
  parameter int BUS_AW     = 8,
  parameter int SLOTS      = 8,
  parameter int SLOT_BYTES = 2048
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [BUS_AW-1:0] bus_addr_i,
  input  logic [DW-1:0]     bus_wdata_i,
  output logic [DW-1:0]     bus_rdata_o,
  input  logic              frame_i,
  output logic              wr_en_o,
  output logic [DW-1:0]     wr_addr_o,
  output logic              irq_o
);
  localparam int CNT_W   = $clog2(SLOTS + 1);
  localparam int SLOT_SH = $clog2(SLOT_BYTES);
  localparam int NSETS   = 2;

  logic [NSETS-1:0][DW-1:0]    base_w;
  logic [NSETS-1:0][CNT_W-1:0] rem_w, idx_w;
  set_state_e                  st_w [NSETS];
  logic [NSETS-1:0]            done_w, take_w;
  logic take_any, clr_w, act_w, en_w, inrst_w, err_w, ovf_w, ctl_we;

  assign ctl_we = bus_we_i && bus_addr_i == BUS_AW'(OFF_CTRL);

  for (genvar g = 0; g < NSETS; g++) begin : g_set
    logic base_we, len_we, cmd_we;
    assign base_we   = bus_we_i && bus_addr_i == BUS_AW'(g * SET_STRIDE + OFF_BASE);
    assign len_we    = bus_we_i && bus_addr_i == BUS_AW'(g * SET_STRIDE + OFF_LEN);
    assign cmd_we    = bus_we_i && bus_addr_i == BUS_AW'(g * SET_STRIDE + OFF_CMD);
    assign take_w[g] = take_any && (act_w == 1'(g));

    rxpp_set #(.DW(DW), .SLOTS(SLOTS), .CNT_W(CNT_W)) u_set (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clr_i     (clr_w),
      .base_we_i (base_we),
      .len_we_i  (len_we),
      .cmd_we_i  (cmd_we),
      .wdata_i   (bus_wdata_i),
      .take_i    (take_w[g]),
      .base_o    (base_w[g]),
      .rem_o     (rem_w[g]),
      .idx_o     (idx_w[g]),
      .state_o   (st_w[g]),
      .done_o    (done_w[g])
    );
  end

  rxpp_ctrl #(.DW(DW), .CNT_W(CNT_W), .SLOT_SH(SLOT_SH)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .frame_i     (frame_i),
    .ctl_we_i    (ctl_we),
    .ctl_cmd_i   (bus_wdata_i[15:0]),
    .act_state_i (st_w[act_w]),
    .act_rem_i   (rem_w[act_w]),
    .act_base_i  (base_w[act_w]),
    .act_idx_i   (idx_w[act_w]),
    .take_o      (take_any),
    .clr_o       (clr_w),
    .act_o       (act_w),
    .en_o        (en_w),
    .inrst_o     (inrst_w),
    .err_o       (err_w),
    .ovf_o       (ovf_w),
    .wr_en_o     (wr_en_o),
    .wr_addr_o   (wr_addr_o)
  );

  always_comb begin
    bus_rdata_o = '0;
    for (int g = 0; g < NSETS; g++) begin
      if (bus_addr_i == BUS_AW'(g * SET_STRIDE + OFF_BASE)) bus_rdata_o = base_w[g];
      if (bus_addr_i == BUS_AW'(g * SET_STRIDE + OFF_LEN))  bus_rdata_o = DW'(rem_w[g]);
      if (bus_addr_i == BUS_AW'(g * SET_STRIDE + OFF_CMD)) begin
        unique case (st_w[g])
          SET_LOAD: bus_rdata_o = DW'(CMD_LOAD);
          SET_ARM:  bus_rdata_o = DW'(CMD_ARM);
          default:  bus_rdata_o = DW'(CMD_STOP);
        endcase
      end
    end
    if (bus_addr_i == BUS_AW'(OFF_CTRL)) begin
      bus_rdata_o[13]  = err_w;
      bus_rdata_o[8]   = |done_w;
      bus_rdata_o[5]   = act_w;
      bus_rdata_o[4]   = ovf_w;
      bus_rdata_o[3]   = inrst_w;
      bus_rdata_o[2]   = en_w;
      bus_rdata_o[1:0] = done_w;
    end
  end

  assign irq_o = err_w | (|done_w);
endmodule

// File: rtl/rxpp_chk.sv
module rxpp_chk
  import rxpp_pkg::*;
#(
  parameter int BUS_AW = 8,
  parameter int CNT_W  = 4
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  bus_we_i,
  input logic [BUS_AW-1:0]     bus_addr_i,
  input logic [15:0]           cmd_i,
  input logic                  frame_i,
  input logic                  wr_en_o,
  input logic [1:0]            take,
  input logic [1:0][CNT_W-1:0] rem,
  input logic [1:0]            done,
  input logic                  ovf,
  input logic                  en
);
  logic ctl_rst, len_we0, stop0;
  assign ctl_rst = bus_we_i && bus_addr_i == BUS_AW'(OFF_CTRL) && cmd_i == CTL_RST_ENTER;
  assign len_we0 = bus_we_i && bus_addr_i == BUS_AW'(OFF_LEN);
  assign stop0   = bus_we_i && bus_addr_i == BUS_AW'(OFF_CMD) && cmd_i == CMD_STOP;

  assert_wr_after_frame_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> $past(frame_i));
  assert_single_take_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(take));
  assert_rem_dec_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take[0] && !len_we0 |=> (rem[0] + 1'b1) == $past(rem[0]));
  assert_done_last_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take[0] && rem[0] == CNT_W'(1) && !stop0 && !ctl_rst |=> done[0]);
  assert_stop_clears_done_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop0 |=> !done[0]);
  assert_ovf_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf && !ctl_rst |=> ovf);
  assert_no_wr_disabled_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> $past(en));
endmodule

bind rx_pingpong_dma rxpp_chk #(.BUS_AW(BUS_AW), .CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_we_i   (bus_we_i),
  .bus_addr_i (bus_addr_i),
  .cmd_i      (bus_wdata_i[15:0]),
  .frame_i    (frame_i),
  .wr_en_o    (wr_en_o),
  .take       (take_w),
  .rem        (rem_w),
  .done       (done_w),
  .ovf        (ovf_w),
  .en         (en_w)
);

// File: tb/rx_pingpong_dma_tb.sv
`timescale 1ns/1ps
module rx_pingpong_dma_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_we_i = 1'b0;
  logic [7:0]  bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic        frame_i = 1'b0;
  logic        wr_en_o;
  logic [31:0] wr_addr_o;
  logic        irq_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk_i = ~clk_i;

  rx_pingpong_dma u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .frame_i(frame_i),
    .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .irq_o(irq_o)
  );

  // behavioural reference
  logic [31:0] m_base [2];
  int          m_rem [2];
  int          m_idx [2];
  int          m_st [2];   // 0 stopped, 1 loading, 2 armed
  bit          m_done [2];
  bit          m_en, m_inrst, m_err, m_ovf;
  int          m_act;
  bit          m_wr_en;
  logic [31:0] m_wr_addr;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < 2; s++) begin
        m_base[s] = 0; m_rem[s] = 0; m_idx[s] = 0; m_st[s] = 0; m_done[s] = 0;
      end
      m_en = 0; m_inrst = 0; m_err = 0; m_ovf = 0; m_act = 0;
      m_wr_en = 0; m_wr_addr = 0;
    end else begin
      int a;
      bit acc;
      a = m_act;
      acc = frame_i && m_en && m_st[a] == 2 && m_rem[a] != 0;
      m_wr_en = acc;
      if (acc) m_wr_addr = m_base[a] + 32'(m_idx[a] * 2048);
      if (frame_i && m_en && !acc) begin
        if (m_st[a] == 1) m_err = 1; else m_ovf = 1;
      end
      if (acc) begin
        m_rem[a]--; m_idx[a]++;
        if (m_rem[a] == 0) begin m_done[a] = 1; m_act = 1 - a; end
      end
      if (bus_we_i) begin
        for (int s = 0; s < 2; s++) begin
          if (bus_addr_i == 8'(s * 16))     m_base[s] = bus_wdata_i;
          if (bus_addr_i == 8'(s * 16 + 4)) m_rem[s] = (bus_wdata_i > 8) ? 8 : int'(bus_wdata_i);
          if (bus_addr_i == 8'(s * 16 + 8)) begin
            case (bus_wdata_i[15:0])
              16'h0100: begin m_st[s] = 1; m_idx[s] = 0; end
              16'h9800: m_st[s] = 2;
              16'h1100: begin m_st[s] = 0; m_done[s] = 0; end
              default: ;
            endcase
          end
        end
        if (bus_addr_i == 8'h20) begin
          case (bus_wdata_i[15:0])
            16'h8800: begin
              m_inrst = 1; m_en = 0; m_err = 0; m_ovf = 0; m_act = 0;
              for (int s = 0; s < 2; s++) begin m_st[s] = 0; m_done[s] = 0; end
            end
            16'h0400: begin m_inrst = 0; m_en = 1; end
            16'h1000: m_en = 0;
            default: ;
          endcase
        end
      end
    end
  end

  function automatic logic [31:0] m_read(logic [7:0] a);
    logic [31:0] v = 0;
    for (int s = 0; s < 2; s++) begin
      if (a == 8'(s * 16))     v = m_base[s];
      if (a == 8'(s * 16 + 4)) v = 32'(m_rem[s]);
      if (a == 8'(s * 16 + 8)) v = (m_st[s] == 1) ? 32'h0100 : (m_st[s] == 2) ? 32'h9800 : 32'h1100;
    end
    if (a == 8'h20) begin
      v[13] = m_err; v[8] = m_done[0] | m_done[1]; v[5] = 1'(m_act);
      v[4] = m_ovf; v[3] = m_inrst; v[2] = m_en; v[1] = m_done[1]; v[0] = m_done[0];
    end
    return v;
  endfunction

  task automatic check(string req, string what, logic [31:0] got, logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // compare on every falling edge
  always @(negedge clk_i) begin
    if (rst_ni) begin
      check("R3", "wr_en_o", 32'(wr_en_o), 32'(m_wr_en));
      check("R3", "wr_addr_o", wr_addr_o, m_wr_addr);
      check("R9", "irq_o", 32'(irq_o), 32'(m_err | m_done[0] | m_done[1]));
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk_i);
    bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk_i);
    bus_we_i = 1'b0;
  endtask

  task automatic frame(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i); frame_i = 1'b1;
      @(negedge clk_i); frame_i = 1'b0;
    end
    @(negedge clk_i);
  endtask

  task automatic rd(logic [7:0] a, string req);
    @(negedge clk_i);
    bus_addr_i = a;
    #1;
    check(req, $sformatf("read %02h", a), bus_rdata_o, m_read(a));
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    rd(8'h00, "R1"); rd(8'h04, "R1"); rd(8'h08, "R1");
    rd(8'h10, "R1"); rd(8'h14, "R1"); rd(8'h18, "R1"); rd(8'h20, "R1");
    // R10 frame while disabled
    frame(1); rd(8'h20, "R10");
    // channel reset bracket with set loading, as software does it
    wr(8'h20, 32'h8800); rd(8'h20, "R10");
    wr(8'h08, 32'h0100); rd(8'h08, "R4");
    wr(8'h00, 32'h1000_0000); wr(8'h04, 32'd8); wr(8'h08, 32'h9800);
    wr(8'h18, 32'h0100); wr(8'h10, 32'h2000_0000); wr(8'h14, 32'd8); wr(8'h18, 32'h9800);
    wr(8'h20, 32'h0400);
    rd(8'h00, "R2"); rd(8'h10, "R2"); rd(8'h14, "R5"); rd(8'h18, "R4"); rd(8'h20, "R10");
    // R3 slot addresses
    frame(3); rd(8'h04, "R3"); rd(8'h14, "R2");
    // R4 stop, inspect, re-arm
    wr(8'h08, 32'h1100); rd(8'h08, "R4"); rd(8'h04, "R4");
    wr(8'h08, 32'h9800);
    // R6 exhaust set 0
    frame(5); rd(8'h20, "R6"); rd(8'h04, "R6");
    frame(1); rd(8'h14, "R6");
    // R4/R9 stop clears done, then partial reload
    wr(8'h08, 32'h1100); rd(8'h20, "R9");
    wr(8'h08, 32'h0100); wr(8'h00, 32'h3000_0000); wr(8'h04, 32'd3); wr(8'h08, 32'h9800);
    frame(7); rd(8'h20, "R6");
    frame(3); rd(8'h20, "R6");
    // R7 active set armed but empty
    frame(1); rd(8'h20, "R7");
    // R5 clamp
    wr(8'h14, 32'd20); rd(8'h14, "R5");
    // R8 frame against loading set
    wr(8'h18, 32'h0100); frame(1); rd(8'h20, "R8");
    // R4/R10 unknown commands ignored
    wr(8'h18, 32'h5555); rd(8'h18, "R4");
    wr(8'h20, 32'h1234); rd(8'h20, "R10");
    // R10 disable drops frames without flag change
    wr(8'h18, 32'h9800); wr(8'h20, 32'h1000); frame(2); rd(8'h20, "R10"); rd(8'h14, "R10");
    // R10 channel reset clears flags
    wr(8'h20, 32'h8800); rd(8'h20, "R10"); rd(8'h18, "R10");
    wr(8'h20, 32'h0400); rd(8'h20, "R10");
    repeat (3) @(negedge clk_i);
    summary();
  end
endmodule